// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block hands out fetch addresses and sequence numbers to the fetch stage of an in-order pipeline with branch delay slots. It serves several hardware threads. Each thread holds a fetch PC, a flag that says whether that PC may be used, and its own sequence counter. On every cycle in which fetch asks for work, a round-robin arbiter picks one eligible thread. The block then presents that thread's PC, its next sequence number and the predicted next PC, and it advances the thread's state at the clock edge.

Prediction results from decode redirect a thread's PC. Depending on the kind of control instruction, decode may also make the block issue a request to squash younger instructions, with a boundary sequence number that keeps or drops the delay slot. A return that is not predicted stops the thread and blocks the stage that saw it until a squash delivers the resolved PC. Several later stages may request squashes in the same cycle. The block keeps only those that are older than the ones it has already taken that cycle, and it moves the PC to follow the oldest. Threads are switched on with a start PC and switched off, which clears their state.

Top module: `fetch_pc_seq`

## Requirements
- R1: After reset no thread is active. A fetch request is refused (`fetch_grant` low), and `redir_valid`, `blk_valid` and every bit of `unblk_valid` are low.
- R2: A granted fetch presents the thread's PC on `fetch_addr`, its sequence counter on `fetch_sn` and PC+INST_BYTES on `fetch_npc`. At the next edge the PC advances by INST_BYTES and the counter increments by one. Each thread has its own counter, which activation does not reset.
- R3: The grant goes to the first eligible thread after the last granted one, in increasing index order with wrap-around; the search starts at thread 0 after reset. A thread is eligible while it is active, its PC is valid and it has no event this cycle (R10).
- R4: A decode result with `dec_taken` high on a branch (kind 1), an annulling branch (kind 2) or a return (kind 3) loads `dec_target` into the PC. One cycle later it raises `redir_valid` with `redir_tid` equal to the thread and `redir_bound` equal to `dec_sn`+1.
- R5: An annulling branch (kind 2) that is predicted not taken sets the PC to `dec_pc`+2·INST_BYTES. One cycle later it raises `redir_valid` with `redir_bound` equal to `dec_sn`.
- R6: A plain branch (kind 1) that is predicted not taken sets the PC to `dec_pc`+2·INST_BYTES and raises no redirect. Kind 0 (not a control instruction), and any decode result for an inactive thread, change no PC and raise nothing.
- R7: A return (kind 3) that is predicted not taken clears the thread's PC-valid flag and records `dec_stage`. One cycle later it pulses `blk_valid` with the thread and stage. The next squash accepted for that thread pulses that thread's bit of `unblk_valid` one cycle later, with the recorded stage in its `unblk_stage` slot.
- R8: An accepted squash sets the PC to `sq_target` when `sq_is_ctrl` is high and to `sq_pc`+INST_BYTES otherwise, and it sets the PC-valid flag.
- R9: Squash ports are taken in index order within a cycle. A squash is dropped when a squash on the same thread was already accepted in the same cycle with a boundary at or before its own, using wrap-aware 16-bit comparison. When more than one squash is accepted, the last accepted one sets the PC. Squashes in different cycles are never filtered against each other.
- R10: A thread that has a squash port request, a decode result, an activation or a deactivation in a cycle is not granted fetch in that cycle. Deactivation takes priority over activation, activation over squash, and squash over decode.
- R11: Deactivation clears the thread's active and PC-valid flags and its pending block, and resets its squash history. Activation loads `act_pc` into the PC and makes the thread eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TID_W | Thread to activate |
| act_pc | input | PC_W | Start PC for the activated thread |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TID_W | Thread to deactivate |
| fetch_req | input | 1 | Fetch stage asks for an address |
| fetch_grant | output | 1 | A thread was chosen this cycle |
| fetch_tid | output | TID_W | Chosen thread |
| fetch_addr | output | PC_W | Fetch address |
| fetch_sn | output | SEQ_W | Sequence number assigned |
| fetch_npc | output | PC_W | Predicted next PC |
| dec_valid | input | 1 | Decode prediction result present |
| dec_tid | input | TID_W | Thread of the decoded instruction |
| dec_kind | input | 2 | 0 none, 1 branch, 2 annulling branch, 3 return |
| dec_taken | input | 1 | Predicted taken |
| dec_sn | input | SEQ_W | Sequence number of the instruction |
| dec_pc | input | PC_W | PC of the instruction |
| dec_target | input | PC_W | Predicted target |
| dec_stage | input | STG_W | Stage reporting the result |
| sq_valid | input | NSQ | Squash request per port |
| sq_tid | input | NSQ×TID_W | Thread per port |
| sq_bound | input | NSQ×SEQ_W | Squash boundary per port |
| sq_is_ctrl | input | NSQ | Cause was a control instruction |
| sq_pc | input | NSQ×PC_W | PC of the causing instruction |
| sq_target | input | NSQ×PC_W | Resolved target of the causing instruction |
| redir_valid | output | 1 | Squash request raised by a decode redirect |
| redir_tid | output | TID_W | Thread to squash |
| redir_bound | output | SEQ_W | Instructions after this number are squashed |
| blk_valid | output | 1 | Block pulse |
| blk_tid | output | TID_W | Blocked thread |
| blk_stage | output | STG_W | Stage to block |
| unblk_valid | output | NT | Unblock pulse per thread |
| unblk_stage | output | NT×STG_W | Stage to unblock per thread |

## Verification
The filter on same-cycle squashes is tested with a younger squash behind an older one, which must be dropped, and with an older one behind a younger one, which must win. A pair that straddles the 16-bit wrap is included, because a plain magnitude compare would accept it and move the PC to the wrong target. Squashes one cycle apart are also tested, since a filter that ignored the cycle would wrongly drop the second. Each decode kind is run with both predictions, checking the squash boundary and the PC that the next fetch uses. An off-by-one boundary or a lost delay slot would show up in those two values. A fetch that collides with a squash on the only eligible thread must be refused. A block pending across deactivation must not produce a stale unblock, and the round-robin order is followed across changing eligibility masks.

// File: rtl/fps_pkg.sv
package fps_pkg;
   typedef enum logic [1:0] {
      CK_NONE   = 2'd0,
      CK_BRANCH = 2'd1,
      CK_ANNUL  = 2'd2,
      CK_RETURN = 2'd3
   } ctl_kind_e;
endpackage

// File: rtl/fps_rr_arb.sv
// Round-robin pick over a request mask; remembers the last winner.
module fps_rr_arb #(
   parameter int N  = 4,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] last_q;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int i = 1; i <= N; i++) begin
         int c;
         c = (int'(last_q) + i) % N;
         if (!gnt_valid && req[c]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         last_q <= IW'(N - 1);
      else if (gnt_valid) last_q <= gnt_idx;
   end
endmodule

// File: rtl/fps_sq_filter.sv
// Sequential in-cycle filtering of squash ports against per-thread history.
module fps_sq_filter #(
   parameter int NT    = 4,
   parameter int NSQ   = 2,
   parameter int SEQ_W = 16,
   parameter int CYC_W = 16,
   parameter int TID_W = 2,
   parameter int PW    = 1
) (
   input  logic [NT-1:0][SEQ_W-1:0]  st_seq,
   input  logic [NT-1:0][CYC_W-1:0]  st_cyc,
   input  logic [CYC_W-1:0]          cur_cyc,
   input  logic [NSQ-1:0]            v,
   input  logic [NSQ-1:0][TID_W-1:0] tid,
   input  logic [NSQ-1:0][SEQ_W-1:0] bnd,
   output logic [NSQ-1:0]            acc,
   output logic [NT-1:0]             hit,
   output logic [NT-1:0][PW-1:0]     hit_port,
   output logic [NT-1:0][SEQ_W-1:0]  new_seq,
   output logic [NT-1:0][CYC_W-1:0]  new_cyc
);
   logic [SEQ_W-1:0] diff;
   logic             covered;

   always_comb begin
      new_seq  = st_seq;
      new_cyc  = st_cyc;
      hit      = '0;
      hit_port = '0;
      acc      = '0;
      diff     = '0;
      covered  = 1'b0;
      for (int k = 0; k < NSQ; k++) begin
         if (v[k]) begin
            // stored <= bound, wrap-aware: sign bit of (bound - stored) clear
            diff    = bnd[k] - new_seq[tid[k]];
            covered = (new_cyc[tid[k]] == cur_cyc) && !diff[SEQ_W-1];
            if (!covered) begin
               acc[k]                = 1'b1;
               hit[tid[k]]           = 1'b1;
               hit_port[tid[k]]      = PW'(k);
               new_seq[tid[k]]       = bnd[k];
               new_cyc[tid[k]]       = cur_cyc;
            end
         end
      end
   end
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq #(
   parameter int NT         = 4,
   parameter int NSQ        = 2,
   parameter int PC_W       = 32,
   parameter int SEQ_W      = 16,
   parameter int STG_W      = 3,
   parameter int CYC_W      = 16,
   parameter int INST_BYTES = 4,
   parameter int TID_W      = $clog2(NT)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      act_valid,
   input  logic [TID_W-1:0]          act_tid,
   input  logic [PC_W-1:0]           act_pc,
   input  logic                      deact_valid,
   input  logic [TID_W-1:0]          deact_tid,
   input  logic                      fetch_req,
   output logic                      fetch_grant,
   output logic [TID_W-1:0]          fetch_tid,
   output logic [PC_W-1:0]           fetch_addr,
   output logic [SEQ_W-1:0]          fetch_sn,
   output logic [PC_W-1:0]           fetch_npc,
   input  logic                      dec_valid,
   input  logic [TID_W-1:0]          dec_tid,
   input  logic [1:0]                dec_kind,
   input  logic                      dec_taken,
   input  logic [SEQ_W-1:0]          dec_sn,
   input  logic [PC_W-1:0]           dec_pc,
   input  logic [PC_W-1:0]           dec_target,
   input  logic [STG_W-1:0]          dec_stage,
   input  logic [NSQ-1:0]            sq_valid,
   input  logic [NSQ-1:0][TID_W-1:0] sq_tid,
   input  logic [NSQ-1:0][SEQ_W-1:0] sq_bound,
   input  logic [NSQ-1:0]            sq_is_ctrl,
   input  logic [NSQ-1:0][PC_W-1:0]  sq_pc,
   input  logic [NSQ-1:0][PC_W-1:0]  sq_target,
   output logic                      redir_valid,
   output logic [TID_W-1:0]          redir_tid,
   output logic [SEQ_W-1:0]          redir_bound,
   output logic                      blk_valid,
   output logic [TID_W-1:0]          blk_tid,
   output logic [STG_W-1:0]          blk_stage,
   output logic [NT-1:0]             unblk_valid,
   output logic [NT-1:0][STG_W-1:0]  unblk_stage
);
   import fps_pkg::*;

   localparam int PW = (NSQ > 1) ? $clog2(NSQ) : 1;
   localparam logic [PC_W-1:0]  STEP1 = PC_W'(INST_BYTES);
   localparam logic [PC_W-1:0]  STEP2 = PC_W'(2 * INST_BYTES);
   localparam logic [CYC_W-1:0] CYC_FIRST = CYC_W'(1);

   // elaboration-time parameter checks
   generate
      if (NT < 2 || (1 << TID_W) != NT) begin : g_bad_nt
         $error("NT must be a power of two of at least 2");
      end
      if (NSQ < 1) begin : g_bad_nsq
         $error("NSQ must be at least 1");
      end
      if (INST_BYTES < 1 || SEQ_W < 2 || CYC_W < 2) begin : g_bad_w
         $error("instruction size and counter widths must be positive");
      end
   endgenerate

   // per-thread state
   logic [NT-1:0][PC_W-1:0]  pc_q;
   logic [NT-1:0][SEQ_W-1:0] sn_q;
   logic [NT-1:0][SEQ_W-1:0] sqseq_q;
   logic [NT-1:0][CYC_W-1:0] sqcyc_q;
   logic [NT-1:0][STG_W-1:0] bstage_q;
   logic [NT-1:0]            act_q, vld_q, blk_q;
   logic [CYC_W-1:0]         cyc_q;

   // squash filter
   logic [NSQ-1:0]           sq_acc;
   logic [NT-1:0]            sq_hit;
   logic [NT-1:0][PW-1:0]    sq_port;
   logic [NT-1:0][SEQ_W-1:0] sq_nseq;
   logic [NT-1:0][CYC_W-1:0] sq_ncyc;

   fps_sq_filter #(
      .NT(NT), .NSQ(NSQ), .SEQ_W(SEQ_W), .CYC_W(CYC_W), .TID_W(TID_W), .PW(PW)
   ) u_filt (
      .st_seq(sqseq_q), .st_cyc(sqcyc_q), .cur_cyc(cyc_q),
      .v(sq_valid), .tid(sq_tid), .bnd(sq_bound),
      .acc(sq_acc), .hit(sq_hit), .hit_port(sq_port),
      .new_seq(sq_nseq), .new_cyc(sq_ncyc)
   );

   // event masks per thread
   logic [NT-1:0] t_act, t_deact, t_dec, t_sqreq, busy, elig;
   logic [NT-1:0][PC_W-1:0] sq_newpc;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         t_act[t]   = act_valid   && (act_tid   == TID_W'(t));
         t_deact[t] = deact_valid && (deact_tid == TID_W'(t));
         t_dec[t]   = dec_valid   && (dec_tid   == TID_W'(t));
         t_sqreq[t] = 1'b0;
         for (int k = 0; k < NSQ; k++)
            if (sq_valid[k] && sq_tid[k] == TID_W'(t)) t_sqreq[t] = 1'b1;
         busy[t] = t_act[t] | t_deact[t] | t_dec[t] | t_sqreq[t];
         elig[t] = act_q[t] & vld_q[t] & ~busy[t] & fetch_req;
         sq_newpc[t] = sq_is_ctrl[sq_port[t]] ? sq_target[sq_port[t]]
                                              : sq_pc[sq_port[t]] + STEP1;
      end
   end

   // decode result classification
   ctl_kind_e        dk;
   logic             dec_go, dec_redir, dec_blk;
   logic [SEQ_W-1:0] dec_bnd;
   logic [PC_W-1:0]  dec_newpc;

   always_comb begin
      dk        = ctl_kind_e'(dec_kind);
      dec_go    = dec_valid && act_q[dec_tid] && dk != CK_NONE
                  && !t_deact[dec_tid] && !t_act[dec_tid] && !sq_hit[dec_tid];
      dec_redir = dec_go && (dec_taken || dk == CK_ANNUL);
      dec_blk   = dec_go && !dec_taken && dk == CK_RETURN;
      dec_bnd   = dec_taken ? dec_sn + SEQ_W'(1) : dec_sn;
      dec_newpc = dec_taken ? dec_target : dec_pc + STEP2;
   end

   // fetch arbitration
   logic             gnt_v;
   logic [TID_W-1:0] gnt_i;

   fps_rr_arb #(.N(NT), .IW(TID_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(elig), .gnt_valid(gnt_v), .gnt_idx(gnt_i)
   );

   assign fetch_grant = gnt_v;
   assign fetch_tid   = gnt_i;
   assign fetch_addr  = pc_q[gnt_i];
   assign fetch_sn    = sn_q[gnt_i];
   assign fetch_npc   = pc_q[gnt_i] + STEP1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q        <= '0;
         sn_q        <= '0;
         sqseq_q     <= '1;
         sqcyc_q     <= '0;
         bstage_q    <= '0;
         act_q       <= '0;
         vld_q       <= '0;
         blk_q       <= '0;
         cyc_q       <= CYC_FIRST;
         redir_valid <= 1'b0;
         redir_tid   <= '0;
         redir_bound <= '0;
         blk_valid   <= 1'b0;
         blk_tid     <= '0;
         blk_stage   <= '0;
         unblk_valid <= '0;
         unblk_stage <= '0;
      end else begin
         // cycle stamp never returns to zero, the value a cleared history holds
         cyc_q       <= (cyc_q == '1) ? CYC_FIRST : cyc_q + CYC_W'(1);
         redir_valid <= dec_redir;
         redir_tid   <= dec_tid;
         redir_bound <= dec_bnd;
         blk_valid   <= dec_blk;
         blk_tid     <= dec_tid;
         blk_stage   <= dec_stage;
         for (int t = 0; t < NT; t++) begin
            unblk_valid[t] <= 1'b0;
            unblk_stage[t] <= bstage_q[t];
            if (t_deact[t]) begin
               act_q[t]    <= 1'b0;
               vld_q[t]    <= 1'b0;
               blk_q[t]    <= 1'b0;
               bstage_q[t] <= '0;
               sqseq_q[t]  <= '1;
               sqcyc_q[t]  <= '0;
            end else if (t_act[t]) begin
               act_q[t] <= 1'b1;
               vld_q[t] <= 1'b1;
               pc_q[t]  <= act_pc;
            end else if (sq_hit[t]) begin
               pc_q[t]        <= sq_newpc[t];
               vld_q[t]       <= 1'b1;
               sqseq_q[t]     <= sq_nseq[t];
               sqcyc_q[t]     <= sq_ncyc[t];
               unblk_valid[t] <= blk_q[t];
               blk_q[t]       <= 1'b0;
            end else if (dec_go && t_dec[t]) begin
               if (dec_blk) begin
                  vld_q[t]    <= 1'b0;
                  blk_q[t]    <= 1'b1;
                  bstage_q[t] <= dec_stage;
               end else begin
                  pc_q[t] <= dec_newpc;
               end
            end else if (gnt_v && gnt_i == TID_W'(t)) begin
               pc_q[t] <= pc_q[t] + STEP1;
               sn_q[t] <= sn_q[t] + SEQ_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fetch_pc_seq_chk.sv
module fetch_pc_seq_chk #(
   parameter int NT         = 4,
   parameter int NSQ        = 2,
   parameter int PC_W       = 32,
   parameter int SEQ_W      = 16,
   parameter int STG_W      = 3,
   parameter int CYC_W      = 16,
   parameter int INST_BYTES = 4,
   parameter int TID_W      = $clog2(NT)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      fetch_req,
   input logic                      fetch_grant,
   input logic [TID_W-1:0]          fetch_tid,
   input logic [PC_W-1:0]           fetch_addr,
   input logic [SEQ_W-1:0]          fetch_sn,
   input logic [PC_W-1:0]           fetch_npc,
   input logic                      dec_valid,
   input logic [TID_W-1:0]          dec_tid,
   input logic [1:0]                dec_kind,
   input logic                      dec_taken,
   input logic [NSQ-1:0]            sq_valid,
   input logic [NSQ-1:0][TID_W-1:0] sq_tid,
   input logic                      redir_valid,
   input logic [TID_W-1:0]          redir_tid,
   input logic                      blk_valid,
   input logic [TID_W-1:0]          blk_tid
);
   // R2: a grant only answers a request
   a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_grant |-> fetch_req);

   // R2: back-to-back grants to one thread step the counter and follow npc
   a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_grant && $past(fetch_grant) && fetch_tid == $past(fetch_tid))
      |-> (fetch_sn == $past(fetch_sn) + SEQ_W'(1) && fetch_addr == $past(fetch_npc)));

   // R4: a redirect always stems from the previous cycle's decode of that thread
   a_r4_redir_origin: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> ($past(dec_valid) && redir_tid == $past(dec_tid)));

   // R6: a plain not-taken branch never raises a redirect
   a_r6_plain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_kind == 2'd1 && !dec_taken) |=> !redir_valid);

   // R7: a blocked thread is not fetched while the block pulse is out
   a_r7_blocked_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> !(fetch_grant && fetch_tid == blk_tid));

   // R10: a thread with a squash request this cycle is not granted
   generate
      for (genvar k = 0; k < NSQ; k++) begin : g_sqp
         a_r10_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[k] && fetch_grant) |-> (sq_tid[k] != fetch_tid));
      end
   endgenerate
endmodule

bind fetch_pc_seq fetch_pc_seq_chk #(
   .NT(NT), .NSQ(NSQ), .PC_W(PC_W), .SEQ_W(SEQ_W), .STG_W(STG_W),
   .CYC_W(CYC_W), .INST_BYTES(INST_BYTES), .TID_W(TID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_grant(fetch_grant),
   .fetch_tid(fetch_tid), .fetch_addr(fetch_addr), .fetch_sn(fetch_sn),
   .fetch_npc(fetch_npc), .dec_valid(dec_valid), .dec_tid(dec_tid),
   .dec_kind(dec_kind), .dec_taken(dec_taken), .sq_valid(sq_valid),
   .sq_tid(sq_tid), .redir_valid(redir_valid), .redir_tid(redir_tid),
   .blk_valid(blk_valid), .blk_tid(blk_tid)
);

// File: tb/fetch_pc_seq_test.sv
`timescale 1ns/1ps
module fetch_pc_seq_test;
   localparam int NT = 4, NSQ = 2, PC_W = 32, SEQ_W = 16, STG_W = 3, IB = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic act_valid, deact_valid, fetch_req, dec_valid, dec_taken;
   logic [1:0] act_tid, deact_tid, dec_tid, dec_kind;
   logic [PC_W-1:0] act_pc, dec_pc, dec_target;
   logic [SEQ_W-1:0] dec_sn;
   logic [STG_W-1:0] dec_stage;
   logic [NSQ-1:0] sq_valid, sq_is_ctrl;
   logic [NSQ-1:0][1:0] sq_tid;
   logic [NSQ-1:0][SEQ_W-1:0] sq_bound;
   logic [NSQ-1:0][PC_W-1:0] sq_pc, sq_target;
   logic fetch_grant, redir_valid, blk_valid;
   logic [1:0] fetch_tid, redir_tid, blk_tid;
   logic [PC_W-1:0] fetch_addr, fetch_npc;
   logic [SEQ_W-1:0] fetch_sn, redir_bound;
   logic [STG_W-1:0] blk_stage;
   logic [NT-1:0] unblk_valid;
   logic [NT-1:0][STG_W-1:0] unblk_stage;

   fetch_pc_seq #(.NT(NT), .NSQ(NSQ), .PC_W(PC_W), .SEQ_W(SEQ_W), .STG_W(STG_W),
                  .CYC_W(16), .INST_BYTES(IB)) uut (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // bench model of thread state
   logic [PC_W-1:0]  m_pc [NT];
   logic [SEQ_W-1:0] m_sn [NT];
   bit               m_act [NT], m_vld [NT];
   int               m_last = NT - 1;

   task automatic chk(input bit ok, input string r, input longint a, input longint e);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, a, e);
      end
   endtask

   task automatic clr();
      act_valid = 0; act_tid = 0; act_pc = 0; deact_valid = 0; deact_tid = 0;
      fetch_req = 0; dec_valid = 0; dec_tid = 0; dec_kind = 0; dec_taken = 0;
      dec_sn = 0; dec_pc = 0; dec_target = 0; dec_stage = 0;
      sq_valid = 0; sq_is_ctrl = 0; sq_tid = 0; sq_bound = 0; sq_pc = 0; sq_target = 0;
   endtask

   // expects to be called at a falling edge with other inputs already set
   task automatic fetch_chk(input logic [NT-1:0] excl, input string r);
      int exp_t;
      exp_t = -1;
      fetch_req = 1;
      #1;
      for (int i = 1; i <= NT; i++) begin
         int c;
         c = (m_last + i) % NT;
         if (exp_t < 0 && m_act[c] && m_vld[c] && !excl[c]) exp_t = c;
      end
      if (exp_t < 0) begin
         chk(fetch_grant == 0, {r, " no grant"}, fetch_grant, 0);
      end else begin
         chk(fetch_grant == 1, {r, " grant"}, fetch_grant, 1);
         chk(fetch_tid == 2'(exp_t), {r, " tid"}, fetch_tid, exp_t);
         chk(fetch_addr == m_pc[exp_t], {r, " addr"}, fetch_addr, m_pc[exp_t]);
         chk(fetch_sn == m_sn[exp_t], {r, " sn"}, fetch_sn, m_sn[exp_t]);
         chk(fetch_npc == m_pc[exp_t] + IB, {r, " npc"}, fetch_npc, m_pc[exp_t] + IB);
         m_pc[exp_t] = m_pc[exp_t] + IB;
         m_sn[exp_t] = m_sn[exp_t] + 1;
         m_last = exp_t;
      end
   endtask

   task automatic fetch_n(input int n, input string r);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); clr();
         fetch_chk('0, r);
      end
   endtask

   task automatic settle();
      @(negedge clk); clr(); #1;
   endtask

   task automatic activate(input int t, input logic [PC_W-1:0] pc);
      @(negedge clk); clr();
      act_valid = 1; act_tid = 2'(t); act_pc = pc;
      m_act[t] = 1; m_vld[t] = 1; m_pc[t] = pc;
   endtask

   task automatic deactivate(input int t);
      @(negedge clk); clr();
      deact_valid = 1; deact_tid = 2'(t);
      m_act[t] = 0; m_vld[t] = 0;
   endtask

   task automatic decode(input int t, input int kind, input bit tk, input int sn,
                         input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt, input int stg);
      @(negedge clk); clr();
      dec_valid = 1; dec_tid = 2'(t); dec_kind = 2'(kind); dec_taken = tk;
      dec_sn = SEQ_W'(sn); dec_pc = pc; dec_target = tgt; dec_stage = STG_W'(stg);
   endtask

   task automatic sq_set(input int k, input int t, input int bnd, input bit ctl,
                         input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt);
      sq_valid[k] = 1; sq_tid[k] = 2'(t); sq_bound[k] = SEQ_W'(bnd);
      sq_is_ctrl[k] = ctl; sq_pc[k] = pc; sq_target[k] = tgt;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < NT; t++) begin
         m_pc[t] = 0; m_sn[t] = 0; m_act[t] = 0; m_vld[t] = 0;
      end
      clr();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: nothing active after reset
      @(negedge clk); clr(); fetch_chk('0, "R1");
      chk(redir_valid == 0 && blk_valid == 0 && unblk_valid == 0, "R1 outputs quiet",
          {redir_valid, blk_valid, unblk_valid}, 0);

      // R2: single thread sequence
      activate(0, 32'h100);
      fetch_n(3, "R2");

      // R3: round robin across threads, R11 activation
      activate(1, 32'h200); activate(2, 32'h300); activate(3, 32'h400);
      fetch_n(8, "R3");

      // R4: taken branch redirect
      decode(1, 1, 1, 20, 32'h0, 32'h1000, 2);
      settle();
      chk(redir_valid && redir_tid == 1 && redir_bound == 21, "R4 taken bound",
          redir_bound, 21);
      m_pc[1] = 32'h1000;
      // R4: predicted-taken return behaves as a taken branch
      decode(3, 3, 1, 7, 32'h0, 32'h3000, 2);
      settle();
      chk(redir_valid && redir_tid == 3 && redir_bound == 8, "R4 return taken",
          redir_bound, 8);
      chk(blk_valid == 0, "R4 no block", blk_valid, 0);
      m_pc[3] = 32'h3000;

      // R5: annulling not taken
      decode(2, 2, 0, 30, 32'h300, 32'h9999, 2);
      settle();
      chk(redir_valid && redir_tid == 2 && redir_bound == 30, "R5 annul bound",
          redir_bound, 30);
      m_pc[2] = 32'h308;

      // R6: plain not taken, then non-control
      decode(3, 1, 0, 40, 32'h400, 32'h9999, 2);
      settle();
      chk(redir_valid == 0, "R6 plain no redirect", redir_valid, 0);
      m_pc[3] = 32'h408;
      decode(0, 0, 1, 41, 32'h0, 32'h9999, 2);
      settle();
      chk(redir_valid == 0, "R6 non-control ignored", redir_valid, 0);
      fetch_n(8, "R4/R5/R6 pc");

      // R7: unpredicted return blocks thread 1
      decode(1, 3, 0, 25, 32'h0, 32'h0, 3);
      settle();
      chk(blk_valid && blk_tid == 1 && blk_stage == 3, "R7 block pulse", blk_stage, 3);
      m_vld[1] = 0;
      fetch_n(6, "R7 skip");
      // R8: non-control squash restores pc, R7 unblock
      @(negedge clk); clr(); sq_set(1, 1, 40, 0, 32'h500, 32'h0);
      settle();
      chk(unblk_valid == 4'b0010, "R7 unblock mask", unblk_valid, 4'b0010);
      chk(unblk_stage[1] == 3, "R7 unblock stage", unblk_stage[1], 3);
      m_vld[1] = 1; m_pc[1] = 32'h504;

      // R9: younger after older dropped; older after younger wins; wrap case
      @(negedge clk); clr();
      sq_set(0, 2, 50, 1, 32'h0, 32'hA00); sq_set(1, 2, 55, 1, 32'h0, 32'hB00);
      m_pc[2] = 32'hA00;
      @(negedge clk); clr();
      sq_set(0, 3, 60, 1, 32'h0, 32'hC00); sq_set(1, 3, 58, 0, 32'hD00, 32'h0);
      m_pc[3] = 32'hD04;
      @(negedge clk); clr();
      sq_set(0, 0, 16'hFFFE, 1, 32'h0, 32'hE00); sq_set(1, 0, 1, 1, 32'h0, 32'hF00);
      m_pc[0] = 32'hE00;
      settle();
      chk(unblk_valid == 0, "R9 no unblock", unblk_valid, 0);
      fetch_n(8, "R8/R9 pc");
      // R9: later cycle is never filtered
      @(negedge clk); clr(); sq_set(0, 2, 10, 1, 32'h0, 32'h5000);
      @(negedge clk); clr(); sq_set(0, 2, 70, 1, 32'h0, 32'h7000);
      m_pc[2] = 32'h7000;
      fetch_n(4, "R9 separate cycles");

      // R10: squash on a thread collides with fetch
      @(negedge clk); clr(); sq_set(0, 2, 90, 1, 32'h0, 32'h9000);
      fetch_chk(4'b0100, "R10 squash beats fetch");
      m_pc[2] = 32'h9000;
      // R10: sole eligible thread refused while squashed
      deactivate(1); deactivate(3); deactivate(0);
      @(negedge clk); clr(); sq_set(1, 2, 95, 0, 32'h6000, 32'h0);
      fetch_chk(4'b0100, "R10 sole thread refused");
      m_pc[2] = 32'h6004;
      fetch_n(2, "R10 after squash");

      // R11: reactivation, and block cleared by deactivation
      activate(0, 32'h2000);
      fetch_n(4, "R11 reactivate");
      decode(2, 3, 0, 99, 32'h0, 32'h0, 5);
      settle();
      chk(blk_valid && blk_tid == 2 && blk_stage == 5, "R7 block t2", blk_stage, 5);
      m_vld[2] = 0;
      deactivate(2);
      activate(2, 32'h2400);
      @(negedge clk); clr(); sq_set(0, 2, 120, 1, 32'h0, 32'h2800);
      m_pc[2] = 32'h2800;
      settle();
      chk(unblk_valid == 0, "R11 no stale unblock", unblk_valid, 0);
      fetch_n(4, "R11 pc");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule